// File: doc/BRIEF.md
# Two-Wire Bus Activity and Role Monitor

This block watches the data and clock lines of a two-wire (I2C) bus and keeps two status flags for the surrounding controller. The first flag tells whether the bus is occupied. It goes up as soon as either line is seen low and drops again only when a STOP condition appears. It keeps following the bus even while the controller is switched off. The second flag tells whether the controller currently owns the bus as master (1) or acts as a slave (0).

The controller raises the role flag by sending a one-cycle pulse once it has put a START on the bus. The role flag falls back to slave in three cases: a STOP seen on the bus, a pulse reporting lost arbitration, or the controller being disabled. A clear always beats a set in the same cycle. Both raw bus lines pass through a parameterised synchronizer chain. The block also gives single-cycle START and STOP detection pulses to the rest of the controller.

Top module: `i2c_bus_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busBusy`, `masterMode`, `startDet` and `stopDet` are all 0. The synchronizers reset to the idle (high) line level.
- R2: Each bus line passes through two synchronizer flops. A change on `sdaIn` that is driven before clock edge k shows up in the detection logic after edge k+1, so a resulting pulse is high from edge k+1 to edge k+2.
- R3: `startDet` is high for exactly one cycle when the synchronized data line goes from 1 to 0 while the synchronized clock line is 1 in both the current and the previous sample.
- R4: `stopDet` is high for exactly one cycle when the synchronized data line goes from 0 to 1 while the synchronized clock line is 1 in both the current and the previous sample.
- R5: A data line change while the clock line is low produces neither `startDet` nor `stopDet`.
- R6: `busBusy` becomes 1 on the clock edge after either synchronized line is seen at 0.
- R7: `busBusy` returns to 0 on the clock edge after a cycle in which `stopDet` is 1, provided that both lines are high.
- R8: `busBusy` is set and cleared in the same way whatever the value of `enable`.
- R9: With `enable` at 1 and no clear condition, a 1 on `masterStartPulse` makes `masterMode` 1 on the next edge. It then holds until a clear condition occurs.
- R10: `masterMode` goes to 0 on the edge after a cycle with `stopDet` at 1, or with `arbLostPulse` at 1.
- R11: `masterMode` goes to 0 on the edge after any cycle with `enable` at 0. A `masterStartPulse` in such a cycle has no effect.
- R12: If `masterStartPulse` falls in the same cycle as a clear condition (STOP, arbitration loss or disable), `masterMode` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sdaIn | input | 1 | Raw bus data line level |
| sclIn | input | 1 | Raw bus clock line level |
| enable | input | 1 | Controller enable |
| masterStartPulse | input | 1 | One-cycle pulse: controller has generated a START as master |
| arbLostPulse | input | 1 | One-cycle pulse: arbitration lost |
| busBusy | output | 1 | Bus occupied flag |
| masterMode | output | 1 | Role flag, 1 = master, 0 = slave |
| startDet | output | 1 | One-cycle START detection pulse |
| stopDet | output | 1 | One-cycle STOP detection pulse |

## Verification
On every cycle the assertions check the following. Each detection pulse lasts one cycle, and the two pulses never overlap. A START pulse is always followed by a busy bus, and a STOP pulse by an idle one. The role flag drops after a disable or an arbitration loss, and it rises only after an enabled start pulse. Some behaviour only the bench scenarios can show, by driving real line sequences against a behavioural model. This covers the exact two-flop latency and the fact that data changes while the clock is low are ignored. It also covers busy tracking with the controller disabled, and a STOP arriving in the same cycle as a start pulse.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  // strobes the line datapath hands to the flag control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic lineLow;
  } lineEvt_t;
endpackage

// File: rtl/i2c_mon_lines.sv
module i2c_mon_lines
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sdaIn,
  input  logic     sclIn,
  output lineEvt_t evt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sdaChain;
  logic [LAST:0] sclChain;
  logic sdaPrev, sclPrev;
  logic sdaNow, sclNow;

  // synchronizer chains, idle bus level is high
  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sdaChain[g] <= 1'b1;
            sclChain[g] <= 1'b1;
          end else begin
            sdaChain[g] <= sdaIn;
            sclChain[g] <= sclIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sdaChain[g] <= 1'b1;
            sclChain[g] <= 1'b1;
          end else begin
            sdaChain[g] <= sdaChain[g-1];
            sclChain[g] <= sclChain[g-1];
          end
        end
      end
    end
  endgenerate

  assign sdaNow = sdaChain[LAST];
  assign sclNow = sclChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPrev <= 1'b1;
      sclPrev <= 1'b1;
    end else begin
      sdaPrev <= sdaNow;
      sclPrev <= sclNow;
    end
  end

  always_comb begin
    evt.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.lineLow   = ~sdaNow | ~sclNow;
  end
endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags
  import i2c_mon_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  lineEvt_t evt,
  input  logic     enable,
  input  logic     masterStartPulse,
  input  logic     arbLostPulse,
  output logic     busBusy,
  output logic     masterMode
);
  logic busyNext, modeNext, modeClear;

  // busy ignores enable on purpose
  always_comb begin
    busyNext = busBusy;
    if (evt.lineLow)       busyNext = 1'b1;
    else if (evt.stopSeen) busyNext = 1'b0;
  end

  // any clear source wins over the set
  assign modeClear = evt.stopSeen | arbLostPulse | ~enable;

  always_comb begin
    modeNext = masterMode;
    if (modeClear)             modeNext = 1'b0;
    else if (masterStartPulse) modeNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busBusy    <= 1'b0;
      masterMode <= 1'b0;
    end else begin
      busBusy    <= busyNext;
      masterMode <= modeNext;
    end
  end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdaIn,
  input  logic sclIn,
  input  logic enable,
  input  logic masterStartPulse,
  input  logic arbLostPulse,
  output logic busBusy,
  output logic masterMode,
  output logic startDet,
  output logic stopDet
);
  lineEvt_t evt;

  i2c_mon_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk   (clk),
    .rstN  (rstN),
    .sdaIn (sdaIn),
    .sclIn (sclIn),
    .evt   (evt)
  );

  i2c_mon_flags u_flags (
    .clk              (clk),
    .rstN             (rstN),
    .evt              (evt),
    .enable           (enable),
    .masterStartPulse (masterStartPulse),
    .arbLostPulse     (arbLostPulse),
    .busBusy          (busBusy),
    .masterMode       (masterMode)
  );

  assign startDet = evt.startSeen;
  assign stopDet  = evt.stopSeen;
endmodule

// File: rtl/i2c_mon_checker.sv
module i2c_mon_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic masterStartPulse,
  input logic arbLostPulse,
  input logic busBusy,
  input logic masterMode,
  input logic startDet,
  input logic stopDet
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !startDet) else $error("start pulse too long"); // R3
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !stopDet) else $error("stop pulse too long"); // R4
  AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet)) else $error("start and stop together"); // R5
  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> busBusy) else $error("busy not set after start"); // R6
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !busBusy) else $error("busy not cleared after stop"); // R7
  AST_ROLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (enable && masterStartPulse && !stopDet && !arbLostPulse) |=> masterMode)
    else $error("master role not taken"); // R9
  AST_ARB_DROPS_ROLE: assert property (@(posedge clk) disable iff (!rstN)
    (arbLostPulse || stopDet) |=> !masterMode) else $error("role kept after clear"); // R10
  AST_DISABLE_DROPS_ROLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !masterMode) else $error("role kept while disabled"); // R11
  AST_ROLE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterMode) |-> $past(masterStartPulse && enable && !arbLostPulse))
    else $error("role rose without enabled start"); // R12
endmodule

bind i2c_bus_monitor i2c_mon_checker u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .enable           (enable),
  .masterStartPulse (masterStartPulse),
  .arbLostPulse     (arbLostPulse),
  .busBusy          (busBusy),
  .masterMode       (masterMode),
  .startDet         (startDet),
  .stopDet          (stopDet)
);

// File: tb/test_i2c_bus_monitor.sv
module test_i2c_bus_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sdaIn = 1'b1, sclIn = 1'b1, enable = 1'b0;
  logic masterStartPulse = 1'b0, arbLostPulse = 1'b0;
  logic busBusy, masterMode, startDet, stopDet;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string phase = "R1";

  always #10 clk = ~clk; // 50 MHz

  i2c_bus_monitor i_i2c_bus_monitor (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn), .enable(enable),
    .masterStartPulse(masterStartPulse), .arbLostPulse(arbLostPulse),
    .busBusy(busBusy), .masterMode(masterMode), .startDet(startDet), .stopDet(stopDet)
  );

  // behavioural reference: history of sampled line values
  bit sdaQ[$] = '{1'b1, 1'b1, 1'b1};
  bit sclQ[$] = '{1'b1, 1'b1, 1'b1};
  bit mBusy = 1'b0, mMaster = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      sdaQ = '{1'b1, 1'b1, 1'b1};
      sclQ = '{1'b1, 1'b1, 1'b1};
      mBusy = 1'b0;
      mMaster = 1'b0;
    end else begin
      bit wasLow, wasStop;
      wasLow  = !sdaQ[1] || !sclQ[1];
      wasStop = sclQ[1] && sclQ[0] && !sdaQ[0] && sdaQ[1];
      if (wasLow) mBusy = 1'b1;
      else if (wasStop) mBusy = 1'b0;
      if (wasStop || arbLostPulse || !enable) mMaster = 1'b0;
      else if (masterStartPulse) mMaster = 1'b1;
      sdaQ.push_back(sdaIn); void'(sdaQ.pop_front());
      sclQ.push_back(sclIn); void'(sclQ.pop_front());
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(phase, "busBusy", busBusy, mBusy);
      check(phase, "masterMode", masterMode, mMaster);
      check(phase, "startDet", startDet,
            sclQ[1] && sclQ[0] && sdaQ[0] && !sdaQ[1]);
      check(phase, "stopDet", stopDet,
            sclQ[1] && sclQ[0] && !sdaQ[0] && sdaQ[1]);
    end
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    masterStartPulse = 1'b1; tick(1); masterStartPulse = 1'b0;
  endtask

  initial begin
    tick(2);
    // R1: reset state
    check("R1", "busBusy", busBusy, 1'b0);
    check("R1", "masterMode", masterMode, 1'b0);
    check("R1", "startDet", startDet, 1'b0);
    check("R1", "stopDet", stopDet, 1'b0);
    rstN = 1'b1;
    enable = 1'b1;
    tick(3);

    // R2/R3: START with exact latency
    phase = "R3";
    sdaIn = 1'b0;
    tick(1);
    check("R2", "startDet early", startDet, 1'b0);
    tick(1);
    check("R2", "startDet latency", startDet, 1'b1);
    phase = "R6";
    tick(2);
    check("R6", "busBusy after start", busBusy, 1'b1);

    // R9: master role taken
    phase = "R9";
    pulseStart();
    tick(2);

    // R5: data changes while clock low
    phase = "R5";
    for (int b = 0; b < 6; b++) begin
      sclIn = 1'b0; tick(2);
      sdaIn = b[0]; tick(3);
      sclIn = 1'b1; tick(3);
    end
    sclIn = 1'b0; tick(2);
    sdaIn = 1'b0; tick(3);
    sclIn = 1'b1; tick(3);

    // R4/R7/R10: STOP clears busy and role
    phase = "R4";
    sdaIn = 1'b1;
    tick(2);
    check("R4", "stopDet", stopDet, 1'b1);
    tick(1);
    check("R7", "busBusy after stop", busBusy, 1'b0);
    check("R10", "masterMode after stop", masterMode, 1'b0);
    tick(2);

    // R10: arbitration loss
    phase = "R10";
    sdaIn = 1'b0; tick(4);
    pulseStart(); tick(2);
    arbLostPulse = 1'b1; tick(1); arbLostPulse = 1'b0;
    check("R10", "masterMode after arb loss", masterMode, 1'b0);
    tick(2);
    sdaIn = 1'b1; tick(4);

    // R8/R11: disabled, busy still tracks, role cannot be taken
    phase = "R8";
    pulseStart(); tick(1);
    enable = 1'b0; tick(2);
    phase = "R11";
    pulseStart(); tick(1);
    check("R11", "masterMode while disabled", masterMode, 1'b0);
    phase = "R8";
    sclIn = 1'b0; tick(4);
    check("R8", "busBusy disabled scl low", busBusy, 1'b1);
    sdaIn = 1'b0; tick(2); sclIn = 1'b1; tick(3);
    sdaIn = 1'b1; tick(4);
    check("R8", "busBusy disabled stop", busBusy, 1'b0);
    enable = 1'b1; tick(2);

    // R12: STOP and start pulse in the same cycle
    phase = "R12";
    sdaIn = 1'b0; tick(4);
    pulseStart(); tick(2);
    sdaIn = 1'b1;
    tick(2);
    masterStartPulse = 1'b1; tick(1); masterStartPulse = 1'b0;
    check("R12", "masterMode stop beats set", masterMode, 1'b0);
    tick(2);
    // R12: arbitration loss together with start pulse
    arbLostPulse = 1'b1; masterStartPulse = 1'b1; tick(1);
    arbLostPulse = 1'b0; masterStartPulse = 1'b0;
    check("R12", "masterMode arb beats set", masterMode, 1'b0);
    tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule